// File: doc/BRIEF.md
# Reset-Time Pin Function Selector

This block decides, from reset onward, the electrical state of each pin of an eight-bit general-purpose port. Some of these pins can also carry external bus control signals. For each pin it produces three controls: a weak-pullup enable, a push-pull drive enable, and a select that chooses between port data and the pin's system control function. Each pin keeps its weak pullup until the event that owns it occurs.

- The read-strobe pin is owned by an external-access strap, which is sampled on the first clock edge after reset is released.
- The byte-high-enable pin and the ready pin are owned by a one-time configuration-fetch strobe. That strobe carries a bus-width bit and a three-bit wait-state code.
- Every pin is also owned by a software write to the per-pin mode register. Such a write releases the pullups of all pins, even when the value written matches the reset configuration.

A hazard flag warns when the fetched configuration has made the ready pin a control input and software later turns that function off. In that state, external accesses could stall while waiting for ready.

Pin roles:

| Pin index | Role |
|---|---|
| 3 | Read strobe |
| 4 | Sleep interrupt |
| 5 | Byte-high enable |
| 6 | Ready |
| All others | Plain I/O |

Top module: `pin_func_sel`

## Requirements
- R1: While reset is held, and after it until the owning event of a pin, that pin has pullup_en_o=1, drive_en_o=0 and func_sel_o=0. This holds for every pin, including the sleep-interrupt pin (index 4) and the plain I/O pins.
- R2: If ext_strap_i is 0 on the first clock edge after reset release, the read pin (index 3) reads func_sel_o=1, drive_en_o=1, pullup_en_o=0 after that edge.
- R3: If ext_strap_i is 1 on that first edge, the read pin stays weakly held until a mode write. Later changes of ext_strap_i have no effect.
- R4: On an accepted cfg_done_i with cfg_bus_wide_i=1, the byte-high pin (index 5) becomes a push-pull control output after the edge. With cfg_bus_wide_i=0 it stays weakly held until a mode write.
- R5: On an accepted cfg_done_i with cfg_wait_i=3'b111, the ready pin (index 6) becomes a control input: func_sel_o=1, drive_en_o=0, pullup_en_o=0. For any other code it stays weakly held, with func_sel_o=0, until a mode write.
- R6: A mode_we_i pulse loads mode_wdata_i into the mode register and releases every pullup from the next edge. For released pins:
  - a mode bit of 1 selects the control function, with push-pull drive only on the read and byte-high pins;
  - a mode bit of 0 selects port data, with drive_en_o following dir_i.
- R7: A released pullup stays released until reset, whatever later strap, fetch or write activity occurs.
- R8: cfg_done_i is ignored while reset is held, and every strobe after the first accepted one is ignored.
- R9: ready_hazard_o is 1 exactly when the fetched code selected the ready function and the ready pin's mode bit has since been cleared.
- R10: When a mode write and an accepted fetch fall on the same edge, the written mode bits win. The fetch still records whether the ready function was selected, for R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_strap_i | input | 1 | External-access strap (0 = external) |
| cfg_done_i | input | 1 | Configuration-fetch done strobe |
| cfg_bus_wide_i | input | 1 | Fetched bus-width bit |
| cfg_wait_i | input | 3 | Fetched wait-state code |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 8 | Mode register write data, one bit per pin |
| dir_i | input | 8 | Port direction from the port data logic, 1 = output |
| pullup_en_o | output | 8 | Weak pullup enable per pin |
| drive_en_o | output | 8 | Push-pull drive enable per pin |
| func_sel_o | output | 8 | 1 = system control function, 0 = port data |
| ready_hazard_o | output | 1 | Ready function disabled after being fetched |

## Verification
A software mode write and the one accepted configuration-fetch strobe can land on the same clock edge. The bench provokes this by raising mode_we_i and cfg_done_i in the same cycle with wait code 3'b111 and the ready mode bit cleared. It then judges that the written bits alone set the mode, that all pullups are released, and that the hazard flag rises after that edge. A second overlap pairs the strap-sampling edge with a write and checks that the read pin takes the written bit.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int WS_W = 3;

  // hardware-owned function enables raised on one edge
  typedef struct packed {
    logic rd_ctrl;
    logic bhe_ctrl;
    logic rdy_ctrl;
  } boot_evt_t;
endpackage

// File: rtl/pfs_boot_cfg.sv
module pfs_boot_cfg
  import pfs_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_strap_i,
  input  logic            cfg_done_i,
  input  logic            cfg_bus_wide_i,
  input  logic [WS_W-1:0] cfg_wait_i,
  output boot_evt_t       evt_o,
  output logic            rdy_sel_o
);
  logic started_q, fetch_seen_q, rdy_sel_q;
  logic fetch_take;

  assign fetch_take = cfg_done_i & ~fetch_seen_q;

  always_comb begin
    evt_o.rd_ctrl  = ~started_q & ~ext_strap_i;
    evt_o.bhe_ctrl = fetch_take & cfg_bus_wide_i;
    evt_o.rdy_ctrl = fetch_take & (&cfg_wait_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q    <= 1'b0;
      fetch_seen_q <= 1'b0;
      rdy_sel_q    <= 1'b0;
    end else begin
      started_q <= 1'b1;
      if (fetch_take) begin
        fetch_seen_q <= 1'b1;
        rdy_sel_q    <= &cfg_wait_i;
      end
    end
  end

  assign rdy_sel_o = rdy_sel_q;

  AST_FETCH_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_seen_q |=> $stable(rdy_sel_q)) else $error("fetch accepted twice"); // R8
endmodule

// File: rtl/pfs_mode_reg.sv
module pfs_mode_reg
  import pfs_pkg::*;
#(
  parameter int N_PINS  = 8,
  parameter int RD_PIN  = 3,
  parameter int BHE_PIN = 5,
  parameter int RDY_PIN = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  boot_evt_t         evt_i,
  input  logic              we_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] mode_o,
  output logic [N_PINS-1:0] rel_o
);
  logic [N_PINS-1:0] mode_q, rel_q, hw_set;

  always_comb begin
    hw_set          = '0;
    hw_set[RD_PIN]  = evt_i.rd_ctrl;
    hw_set[BHE_PIN] = evt_i.bhe_ctrl;
    hw_set[RDY_PIN] = evt_i.rdy_ctrl;
  end

  // a software write overrides hardware-set bits on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      rel_q  <= '0;
    end else if (we_i) begin
      mode_q <= wdata_i;
      rel_q  <= '1;
    end else begin
      mode_q <= mode_q | hw_set;
      rel_q  <= rel_q | hw_set;
    end
  end

  assign mode_o = mode_q;
  assign rel_o  = rel_q;

  AST_REL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(rel_q) & ~rel_q) == '0)) else $error("pullup re-enabled"); // R7
  AST_WRITE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (&rel_q)) else $error("write left a pullup on"); // R6
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mode_q == $past(wdata_i))) else $error("write value lost"); // R10
endmodule

// File: rtl/pfs_pin_drive.sv
module pfs_pin_drive #(
  parameter int                N_PINS   = 8,
  parameter logic [N_PINS-1:0] CTRL_OUT = '0
) (
  input  logic [N_PINS-1:0] mode_i,
  input  logic [N_PINS-1:0] rel_i,
  input  logic [N_PINS-1:0] dir_i,
  output logic [N_PINS-1:0] pullup_en_o,
  output logic [N_PINS-1:0] drive_en_o,
  output logic [N_PINS-1:0] func_sel_o
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    always_comb begin
      pullup_en_o[i] = ~rel_i[i];
      func_sel_o[i]  = rel_i[i] & mode_i[i];
      drive_en_o[i]  = rel_i[i] & (mode_i[i] ? CTRL_OUT[i] : dir_i[i]);
    end
  end
endmodule

// File: rtl/pin_func_sel.sv
module pin_func_sel
  import pfs_pkg::*;
#(
  parameter int N_PINS  = 8,
  parameter int RD_PIN  = 3,
  parameter int BHE_PIN = 5,
  parameter int RDY_PIN = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_strap_i,
  input  logic              cfg_done_i,
  input  logic              cfg_bus_wide_i,
  input  logic [WS_W-1:0]   cfg_wait_i,
  input  logic              mode_we_i,
  input  logic [N_PINS-1:0] mode_wdata_i,
  input  logic [N_PINS-1:0] dir_i,
  output logic [N_PINS-1:0] pullup_en_o,
  output logic [N_PINS-1:0] drive_en_o,
  output logic [N_PINS-1:0] func_sel_o,
  output logic              ready_hazard_o
);
  localparam logic [N_PINS-1:0] CTRL_OUT =
    (N_PINS'(1) << RD_PIN) | (N_PINS'(1) << BHE_PIN);

  boot_evt_t         evt;
  logic              rdy_sel;
  logic [N_PINS-1:0] mode, rel;

  pfs_boot_cfg u_boot (
    .clk_i, .rst_ni, .ext_strap_i, .cfg_done_i, .cfg_bus_wide_i, .cfg_wait_i,
    .evt_o(evt), .rdy_sel_o(rdy_sel)
  );

  pfs_mode_reg #(.N_PINS(N_PINS), .RD_PIN(RD_PIN), .BHE_PIN(BHE_PIN),
                 .RDY_PIN(RDY_PIN)) u_mode (
    .clk_i, .rst_ni, .evt_i(evt), .we_i(mode_we_i), .wdata_i(mode_wdata_i),
    .mode_o(mode), .rel_o(rel)
  );

  pfs_pin_drive #(.N_PINS(N_PINS), .CTRL_OUT(CTRL_OUT)) u_drive (
    .mode_i(mode), .rel_i(rel), .dir_i,
    .pullup_en_o, .drive_en_o, .func_sel_o
  );

  assign ready_hazard_o = rdy_sel & ~mode[RDY_PIN];

  AST_RD_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pullup_en_o[RD_PIN]) |-> ($past(mode_we_i) || !$past(ext_strap_i)))
    else $error("read pin released without owner"); // R3
  AST_BHE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pullup_en_o[BHE_PIN]) |-> ($past(mode_we_i) || $past(cfg_done_i)))
    else $error("byte-high pin released without owner"); // R4
  AST_RDY_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_sel_o[RDY_PIN] |-> !drive_en_o[RDY_PIN]) else $error("ready driven"); // R5
  AST_HAZARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_hazard_o |-> !func_sel_o[RDY_PIN]) else $error("hazard with ready on"); // R9
  AST_RESET_WEAK: assert property (@(posedge clk_i)
    !rst_ni |-> (&pullup_en_o && drive_en_o == '0)) else $error("not weak in reset"); // R1
endmodule

// File: tb/pin_func_sel_tb.sv
module pin_func_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8, RD = 3, BHE = 5, RDY = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ext_strap_i = 1'b1, cfg_done_i = 1'b0, cfg_bus_wide_i = 1'b0;
  logic [2:0] cfg_wait_i = '0;
  logic mode_we_i = 1'b0;
  logic [N-1:0] mode_wdata_i = '0, dir_i = '0;
  logic [N-1:0] pullup_en_o, drive_en_o, func_sel_o;
  logic ready_hazard_o;

  pin_func_sel u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model state
  bit m_started, m_fseen, m_rdysel;
  bit [N-1:0] m_mode, m_rel;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  task automatic check(string what, logic [N-1:0] act, logic [N-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_started = 0; m_fseen = 0; m_rdysel = 0; m_mode = '0; m_rel = '0;
    end else begin
      bit [N-1:0] hw;
      hw = '0;
      if (!m_started && !ext_strap_i) hw[RD] = 1;
      m_started = 1;
      if (cfg_done_i && !m_fseen) begin
        m_fseen = 1;
        if (cfg_bus_wide_i) hw[BHE] = 1;
        m_rdysel = (cfg_wait_i == 3'b111);
        if (m_rdysel) hw[RDY] = 1;
      end
      if (mode_we_i) begin
        m_mode = mode_wdata_i; m_rel = '1;
      end else begin
        m_mode |= hw; m_rel |= hw;
      end
    end
    #(CLK_PERIOD/4);
    begin
      bit [N-1:0] e_pu, e_fs, e_dr;
      for (int i = 0; i < N; i++) begin
        e_pu[i] = !m_rel[i];
        e_fs[i] = m_rel[i] && m_mode[i];
        e_dr[i] = m_rel[i] && (m_mode[i] ? (i == RD || i == BHE) : dir_i[i]);
      end
      check("pullup_en_o", pullup_en_o, e_pu);
      check("func_sel_o", func_sel_o, e_fs);
      check("drive_en_o", drive_en_o, e_dr);
      check("ready_hazard_o", N'(ready_hazard_o), N'(m_rdysel && !m_mode[RDY]));
    end
  end

  task automatic restart(bit strap);
    rst_ni = 0; ext_strap_i = strap; cfg_done_i = 0; mode_we_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic fetch(bit bw, logic [2:0] ws);
    cfg_done_i = 1; cfg_bus_wide_i = bw; cfg_wait_i = ws;
    @(negedge clk_i);
    cfg_done_i = 0;
  endtask

  task automatic write(logic [N-1:0] v);
    mode_we_i = 1; mode_wdata_i = v;
    @(negedge clk_i);
    mode_we_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk_i);
    // R1 R3: strap high, nothing owned yet, later strap changes ignored
    cur_req = "R1"; restart(1);
    repeat (4) @(negedge clk_i);
    cur_req = "R3"; ext_strap_i = 0;
    repeat (4) @(negedge clk_i);
    // R6 R7: write releases all, dir drives port pins, later write keeps release
    cur_req = "R6"; dir_i = 8'hA5; write(8'h00);
    repeat (2) @(negedge clk_i);
    dir_i = 8'h3C; write(8'hFF);
    @(negedge clk_i);
    cur_req = "R7"; fetch(1, 3'b111); write(8'h00);
    repeat (2) @(negedge clk_i);

    // R2: strap low at release
    cur_req = "R2"; restart(0);
    repeat (3) @(negedge clk_i);

    // R4 R5 R8 R9: wide bus and ready fetched, second fetch ignored, hazard
    cur_req = "R4"; restart(1);
    @(negedge clk_i);
    fetch(1, 3'b111);
    repeat (2) @(negedge clk_i);
    cur_req = "R8"; fetch(0, 3'b000);
    @(negedge clk_i);
    cur_req = "R9"; dir_i = 8'h0F; write(8'h28);
    repeat (2) @(negedge clk_i);
    write(8'h40);
    @(negedge clk_i);

    // R4 R5: narrow bus and other wait code stay weak
    cur_req = "R5"; restart(1);
    fetch(0, 3'b101);
    repeat (3) @(negedge clk_i);
    write(8'h60);
    @(negedge clk_i);

    // R8: fetch strobe during reset ignored
    cur_req = "R8"; rst_ni = 0; ext_strap_i = 1; cfg_done_i = 1;
    cfg_bus_wide_i = 1; cfg_wait_i = 3'b111;
    repeat (3) @(negedge clk_i);
    cfg_done_i = 0; rst_ni = 1;
    repeat (3) @(negedge clk_i);

    // R10: write and fetch on the same edge
    cur_req = "R10"; restart(1);
    @(negedge clk_i);
    cfg_done_i = 1; cfg_bus_wide_i = 1; cfg_wait_i = 3'b111;
    mode_we_i = 1; mode_wdata_i = 8'h11;
    @(negedge clk_i);
    cfg_done_i = 0; mode_we_i = 0;
    repeat (2) @(negedge clk_i);
    // R10: write on the strap-sampling edge
    rst_ni = 0; ext_strap_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1; mode_we_i = 1; mode_wdata_i = 8'h00;
    @(negedge clk_i);
    mode_we_i = 0;
    repeat (2) @(negedge clk_i);
    summary();
  end
endmodule